// File: doc/BRIEF.md
# Serial Interrupt Bus Peripheral Agent

This block is the peripheral end of a serialized interrupt line. The line is shared and open-drain, and the bus clock times it. A host opens each cycle with a start pulse. A fixed train of three-clock time slots follows, and a stop pulse closes the cycle. The agent follows the line and counts slots and phases. For each of its external interrupt inputs, it pulls the line low in the slot that software picked for that input, as long as the input is asserted (high). The agent never drives the line to a static level. It reports the drive through an output enable and a drive value, and the bench or pad resolves them into the shared line.

The width of the stop pulse chooses the mode of the next cycle. In continuous mode the agent only answers cycles that the host starts. In quiet mode, a change on an enabled input while the line is idle makes the agent pull the line low for a single clock. The host is then expected to stretch that pulse into a full start pulse. A small register file holds a 4-bit slot number for each input and a polarity bit for each input. A sticky status bit for each input records an edge of the chosen polarity. Both interrupt inputs are synchronised before use.

Top module: `serirq_slave`

## Requirements
- R1: While rstN is low, lineOe is 0. After reset, stsEdge is 0, quietMode is 0 (continuous), every slot register is 0 and every polarity bit is 0.
- R2: After reset, the agent drives nothing on its own until a valid start pulse arrives, even when inputs change and a slot is enabled.
- R3: A start pulse is lineIn sampled low on 4 to 8 consecutive rising edges. A pulse of any other width is ignored. The first clock with the line high again is count 0. Slot N spans counts 3N, 3N+1 and 3N+2, and the frame ends after 16 slots (counts 0 to 47).
- R4: A stop pulse follows the frame. It is decoded when the line is first sampled high again. A width of 2 selects quiet mode (quietMode=1), a width of 3 selects continuous mode (quietMode=0), and any other width keeps the mode.
- R5: A write with regWe=1 and regAddr=0 or regAddr=1 loads regWdata[3:0] as the slot number of input 0 or input 1. regAddr=2 loads the polarity bits from regWdata[1:0], one bit per input (0 = rising edge, 1 = falling edge). Two inputs can report in two different slots of the same frame.
- R6: In the selected slot, a synchronised high input gives lineOe=1/lineOut=0 at count 3N and lineOe=1/lineOut=1 at count 3N+1, then release at 3N+2. A low input gives no drive.
- R7: A slot number of 0 disables its input, so no drive is ever made for that input.
- R8: stsEdge[i] sets on an edge of the selected polarity and holds until stsClr[i] is 1 at a clock edge. A set and a clear in the same cycle leave the bit set.
- R9: In quiet mode, a change on an enabled input while the line is idle high gives exactly one clock of lineOe=1/lineOut=0, then release. This does not happen in continuous mode or for a disabled input.
- R10: An input change at irqIn reaches stsEdge on the third rising edge after the change (two synchroniser flops plus the edge register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all sampling and driving on its rising edge |
| rstN | input | 1 | Active-low bus reset, asynchronous assert |
| lineIn | input | 1 | Resolved level of the shared serial interrupt line |
| lineOe | output | 1 | Drive enable for the serial line |
| lineOut | output | 1 | Level driven when lineOe is 1 |
| irqIn | input | NUM_IRQ | Asynchronous interrupt inputs, high = asserted |
| regWe | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register select: input slot registers, then polarity |
| regWdata | input | SLOT_W | Register write data |
| stsClr | input | NUM_IRQ | Per-input clear of the edge status |
| stsEdge | output | NUM_IRQ | Sticky edge status per input |
| quietMode | output | 1 | 1 when the next cycle runs in quiet mode |

## Verification
The edge-status path can receive a new edge and a software clear in the same clock. The bench raises input 0 and holds stsClr[0] exactly across the third rising edge after the change, where the edge register fires. It expects the bit to read 1 afterwards. A quiet-mode request can also meet the host start pulse. The bench lets the agent's single-clock pull start the cycle, stretches it from the host side, and checks two things: the agent released after one clock, and the frame that followed carried the input in its slot.

// File: rtl/serirq_pkg.sv
package serirq_pkg;
  localparam int SLOT_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOPWAIT,
    ST_STOP
  } frameState_t;

  typedef struct packed {
    logic              inData;
    logic              phaseSample;
    logic              phaseRecov;
    logic [SLOT_W-1:0] slotIdx;
    logic              quiet;
    logic              lineIdle;
    logic              startSeen;
  } ctrlStrobe_t;
endpackage

// File: rtl/serirq_ctrl.sv
module serirq_ctrl
  import serirq_pkg::*;
#(
  parameter int NUM_SLOTS   = 16,
  parameter int START_MIN   = 4,
  parameter int START_MAX   = 8,
  parameter int QUIET_WIDTH = 2,
  parameter int CONT_WIDTH  = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        lineIn,
  output ctrlStrobe_t stb
);
  localparam int CNT_W = $clog2(START_MAX + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = '1;

  frameState_t       state;
  logic [CNT_W-1:0]  lowCnt;
  logic [CNT_W-1:0]  lowNext;
  logic [1:0]        phase;
  logic [SLOT_W-1:0] slotIdx;
  logic              quietQ;
  logic              lastCount;
  logic              startOk;

  assign lowNext   = (lowCnt == CNT_SAT) ? lowCnt : lowCnt + CNT_W'(1);
  assign lastCount = (slotIdx == SLOT_W'(NUM_SLOTS - 1)) && (phase == 2'd2);
  assign startOk   = (lowCnt >= CNT_W'(START_MIN)) && (lowCnt <= CNT_W'(START_MAX));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      lowCnt  <= '0;
      phase   <= '0;
      slotIdx <= '0;
      quietQ  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (!lineIn) begin
            state  <= ST_START;
            lowCnt <= CNT_W'(1);
          end
        end
        ST_START: begin
          if (!lineIn) begin
            lowCnt <= lowNext;
          end else if (startOk) begin
            state   <= ST_DATA;
            phase   <= 2'd1;
            slotIdx <= '0;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_DATA: begin
          if (lastCount) begin
            state <= ST_STOPWAIT;
          end else if (phase == 2'd2) begin
            phase   <= 2'd0;
            slotIdx <= slotIdx + SLOT_W'(1);
          end else begin
            phase <= phase + 2'd1;
          end
        end
        ST_STOPWAIT: begin
          if (!lineIn) begin
            state  <= ST_STOP;
            lowCnt <= CNT_W'(1);
          end
        end
        ST_STOP: begin
          if (!lineIn) begin
            lowCnt <= lowNext;
          end else begin
            if (lowCnt == CNT_W'(QUIET_WIDTH)) quietQ <= 1'b1;
            else if (lowCnt == CNT_W'(CONT_WIDTH)) quietQ <= 1'b0;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.inData      = (state == ST_DATA);
    stb.phaseSample = (state == ST_DATA) && (phase == 2'd0);
    stb.phaseRecov  = (state == ST_DATA) && (phase == 2'd1);
    stb.slotIdx     = slotIdx;
    stb.quiet       = quietQ;
    stb.lineIdle    = (state == ST_IDLE) && lineIn;
    stb.startSeen   = (state == ST_IDLE) && !lineIn;
  end
endmodule

// File: rtl/serirq_dp.sv
module serirq_dp
  import serirq_pkg::*;
#(
  parameter int NUM_IRQ = 2,
  parameter int ADDR_W  = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_IRQ-1:0]             irqIn,
  input  logic                           regWe,
  input  logic [ADDR_W-1:0]              regAddr,
  input  logic [SLOT_W-1:0]              regWdata,
  input  logic [NUM_IRQ-1:0]             stsClr,
  input  ctrlStrobe_t                    stb,
  output logic                           lineOe,
  output logic                           lineOut,
  output logic [NUM_IRQ-1:0]             stsEdge,
  output logic [NUM_IRQ*SLOT_W-1:0]      slotCfg
);
  logic [NUM_IRQ-1:0] sync1, sync2, prevLvl, polarity, pending, stsQ;
  logic [NUM_IRQ-1:0] enabled, hitSlot, edgeHit, changed;
  logic [NUM_IRQ-1:0][SLOT_W-1:0] slotQ;
  logic recovQ, reqQ, sampleHit, reqFire, pendClr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sync1   <= '0;
      sync2   <= '0;
      prevLvl <= '0;
    end else begin
      sync1   <= irqIn;
      sync2   <= sync1;
      prevLvl <= sync2;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) polarity <= '0;
    else if (regWe && regAddr == ADDR_W'(NUM_IRQ)) polarity <= regWdata[NUM_IRQ-1:0];
  end

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq
    assign enabled[g] = |slotQ[g];
    assign hitSlot[g] = stb.inData && enabled[g] && (slotQ[g] == stb.slotIdx) && sync2[g];
    assign edgeHit[g] = polarity[g] ? (prevLvl[g] & ~sync2[g]) : (~prevLvl[g] & sync2[g]);
    assign changed[g] = enabled[g] & (prevLvl[g] ^ sync2[g]);
    assign slotCfg[g*SLOT_W +: SLOT_W] = slotQ[g];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) slotQ[g] <= '0;
      else if (regWe && regAddr == ADDR_W'(g)) slotQ[g] <= regWdata;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stsQ[g] <= 1'b0;
      else       stsQ[g] <= edgeHit[g] | (stsQ[g] & ~stsClr[g]);
    end
  end

  assign sampleHit = stb.phaseSample && (|hitSlot);
  assign reqFire   = stb.quiet && stb.lineIdle && (|pending) && !reqQ;
  assign pendClr   = stb.startSeen || reqFire;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      recovQ  <= 1'b0;
      reqQ    <= 1'b0;
      pending <= '0;
    end else begin
      recovQ  <= sampleHit;
      reqQ    <= reqFire;
      pending <= (pendClr ? '0 : pending) | (changed & {NUM_IRQ{stb.quiet}});
    end
  end

  assign lineOe  = sampleHit | (recovQ & stb.phaseRecov) | reqQ;
  assign lineOut = recovQ & stb.phaseRecov;
  assign stsEdge = stsQ;
endmodule

// File: rtl/serirq_slave.sv
module serirq_slave
  import serirq_pkg::*;
#(
  parameter int NUM_IRQ     = 2,
  parameter int NUM_SLOTS   = 16,
  parameter int START_MIN   = 4,
  parameter int START_MAX   = 8,
  parameter int QUIET_WIDTH = 2,
  parameter int CONT_WIDTH  = 3,
  localparam int ADDR_W     = $clog2(NUM_IRQ + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lineIn,
  output logic               lineOe,
  output logic               lineOut,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  logic               regWe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [SLOT_W-1:0]  regWdata,
  input  logic [NUM_IRQ-1:0] stsClr,
  output logic [NUM_IRQ-1:0] stsEdge,
  output logic               quietMode
);
  ctrlStrobe_t stb;
  logic [NUM_IRQ*SLOT_W-1:0] slotCfg;

  serirq_ctrl #(
    .NUM_SLOTS(NUM_SLOTS), .START_MIN(START_MIN), .START_MAX(START_MAX),
    .QUIET_WIDTH(QUIET_WIDTH), .CONT_WIDTH(CONT_WIDTH)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .stb(stb)
  );

  serirq_dp #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .stsClr(stsClr), .stb(stb), .lineOe(lineOe),
    .lineOut(lineOut), .stsEdge(stsEdge), .slotCfg(slotCfg)
  );

  assign quietMode = stb.quiet;
endmodule

// File: rtl/serirq_checker.sv
module serirq_checker #(
  parameter int NUM_IRQ = 2,
  parameter int CFG_W   = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               lineOe,
  input logic               lineOut,
  input logic               inData,
  input logic               phaseSample,
  input logic               quietMode,
  input logic [NUM_IRQ-1:0] stsEdge,
  input logic [NUM_IRQ-1:0] stsClr,
  input logic [CFG_W-1:0]   slotCfg
);
  p_recovery_high_r6: assert property (@(posedge clk) disable iff (!rstN)
    (phaseSample && lineOe && !lineOut) |=> (lineOe && lineOut));

  p_turnaround_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    (lineOe && lineOut) |=> !lineOe);

  p_request_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    (lineOe && !lineOut && !inData) |=> !lineOe);

  p_no_request_continuous_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!inData && !quietMode) |-> !lineOe);

  p_disabled_silent_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inData && slotCfg == '0) |-> !lineOe);

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_sts
    p_sticky_status_r8: assert property (@(posedge clk) disable iff (!rstN)
      (stsEdge[g] && !stsClr[g]) |=> stsEdge[g]);
  end
endmodule

bind serirq_slave serirq_checker #(.NUM_IRQ(NUM_IRQ), .CFG_W(NUM_IRQ * serirq_pkg::SLOT_W)) i_chk (
  .clk(clk), .rstN(rstN), .lineOe(lineOe), .lineOut(lineOut),
  .inData(stb.inData), .phaseSample(stb.phaseSample), .quietMode(quietMode),
  .stsEdge(stsEdge), .stsClr(stsClr), .slotCfg(slotCfg)
);

// File: tb/test_serirq_slave.sv
module test_serirq_slave;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME_CNT  = 48;

  logic       clk = 1'b0;
  logic       rstN;
  logic       hostLow;
  logic       lineIn;
  logic       lineOe, lineOut;
  logic [1:0] irqIn;
  logic       regWe;
  logic [1:0] regAddr;
  logic [3:0] regWdata;
  logic [1:0] stsClr;
  logic [1:0] stsEdge;
  logic       quietMode;

  int checks = 0;
  int errors = 0;
  logic [FRAME_CNT-1:0] trOe, trOut;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign lineIn = hostLow ? 1'b0 : (lineOe ? lineOut : 1'b1);

  serirq_slave i_serirq_slave (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .lineOe(lineOe), .lineOut(lineOut),
    .irqIn(irqIn), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .stsClr(stsClr), .stsEdge(stsEdge), .quietMode(quietMode)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic waitNeg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic clearSts();
    @(negedge clk); stsClr = 2'b11;
    @(negedge clk); stsClr = 2'b00;
  endtask

  // Called at the negedge inside count 0; records counts 1..47, then sends the stop pulse.
  task automatic collectFrame(input int stopW);
    trOe = '0; trOut = '0;
    for (int k = 1; k < FRAME_CNT; k++) begin
      @(negedge clk);
      trOe[k] = lineOe; trOut[k] = lineOut;
    end
    @(negedge clk);
    hostLow = 1'b1;
    repeat (stopW) @(negedge clk);
    hostLow = 1'b0;
    waitNeg(2);
  endtask

  task automatic runFrame(input int startW, input int stopW);
    @(negedge clk);
    hostLow = 1'b1;
    repeat (startW) @(negedge clk);
    hostLow = 1'b0;
    collectFrame(stopW);
  endtask

  task automatic checkFrame(input int sA, input int lA, input int sB, input int lB, input string req);
    int bad = -1;
    int actV = 0;
    int expV = 0;
    for (int k = 1; k < FRAME_CNT; k++) begin
      int slot = k / 3;
      int ph = k % 3;
      bit hit = (sA != 0 && slot == sA && lA != 0) || (sB != 0 && slot == sB && lB != 0);
      bit eOe = hit && ph != 2;
      bit eOut = eOe && ph == 1;
      if (bad < 0 && (trOe[k] != eOe || (eOe && trOut[k] != eOut))) begin
        bad = k;
        actV = int'({trOe[k], trOut[k]});
        expV = int'({eOe, eOut});
      end
    end
    check(bad < 0, req, $sformatf("frame drive {oe,out} at count %0d", bad), actV, expV);
  endtask

  task automatic expectSilent(input int n, input string req, input string what);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (lineOe) seen++;
    end
    check(seen == 0, req, what, seen, 0);
  endtask

  task automatic testReset();
    int seen = 0;
    rstN = 1'b0; hostLow = 1'b0; irqIn = 2'b00; regWe = 1'b0;
    regAddr = '0; regWdata = '0; stsClr = 2'b00;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      hostLow = (i % 2) == 0;
      if (lineOe) seen++;
    end
    hostLow = 1'b0;
    check(seen == 0, "R1", "lineOe during reset", seen, 0);
    check(stsEdge == 2'b00, "R1", "stsEdge in reset", int'(stsEdge), 0);
    check(quietMode == 1'b0, "R1", "quietMode in reset", int'(quietMode), 0);
    @(negedge clk); rstN = 1'b1;
    waitNeg(2);
  endtask

  task automatic testResetSlotsZero();
    irqIn = 2'b11;
    waitNeg(4);
    runFrame(4, 3);
    checkFrame(0, 0, 0, 0, "R1");
    irqIn = 2'b00;
    waitNeg(4);
  endtask

  task automatic testNoSelfStart();
    writeReg(2'd0, 4'd5);
    irqIn[0] = 1'b1;
    waitNeg(5);
    irqIn[0] = 1'b0;
    waitNeg(5);
    irqIn[0] = 1'b1;
    expectSilent(40, "R2", "drive cycles before any start pulse");
  endtask

  task automatic testSingleSlot();
    writeReg(2'd1, 4'd0);
    irqIn = 2'b01;
    waitNeg(4);
    runFrame(4, 3);
    checkFrame(5, 1, 0, 0, "R6");
  endtask

  task automatic testTwoSlots();
    writeReg(2'd0, 4'd3);
    writeReg(2'd1, 4'd12);
    irqIn = 2'b11;
    waitNeg(4);
    runFrame(8, 3);
    checkFrame(3, 1, 12, 1, "R5");
  endtask

  task automatic testLevelLow();
    writeReg(2'd1, 4'd15);
    irqIn = 2'b10;
    waitNeg(4);
    runFrame(6, 3);
    checkFrame(3, 0, 15, 1, "R6");
  endtask

  task automatic testDisabled();
    writeReg(2'd0, 4'd0);
    writeReg(2'd1, 4'd0);
    irqIn = 2'b11;
    waitNeg(4);
    runFrame(5, 3);
    checkFrame(0, 1, 0, 1, "R7");
  endtask

  task automatic testBadStart();
    writeReg(2'd0, 4'd2);
    irqIn = 2'b01;
    waitNeg(4);
    @(negedge clk); hostLow = 1'b1;
    waitNeg(3); hostLow = 1'b0;
    expectSilent(55, "R3", "drive after 3-clock start pulse");
    @(negedge clk); hostLow = 1'b1;
    waitNeg(9); hostLow = 1'b0;
    expectSilent(55, "R3", "drive after 9-clock start pulse");
    runFrame(8, 3);
    checkFrame(2, 1, 0, 0, "R3");
  endtask

  task automatic testStopWidth();
    irqIn = 2'b00;
    waitNeg(4);
    runFrame(4, 2);
    check(quietMode == 1'b1, "R4", "quietMode after 2-clock stop", int'(quietMode), 1);
    runFrame(4, 5);
    check(quietMode == 1'b1, "R4", "quietMode after 5-clock stop", int'(quietMode), 1);
    runFrame(4, 3);
    check(quietMode == 1'b0, "R4", "quietMode after 3-clock stop", int'(quietMode), 0);
  endtask

  task automatic testEdgeStatus();
    irqIn = 2'b00;
    writeReg(2'd2, 4'b0000);
    waitNeg(4);
    clearSts();
    check(stsEdge[0] == 1'b0, "R8", "status after clear", int'(stsEdge[0]), 0);
    @(negedge clk); irqIn[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(stsEdge[0] == 1'b0, "R10", "status two edges after rise", int'(stsEdge[0]), 0);
    stsClr = 2'b01;
    @(negedge clk);
    stsClr = 2'b00;
    check(stsEdge[0] == 1'b1, "R8", "set wins over clear on third edge", int'(stsEdge[0]), 1);
    waitNeg(3);
    check(stsEdge[0] == 1'b1, "R8", "status sticky", int'(stsEdge[0]), 1);
    clearSts();
    check(stsEdge[0] == 1'b0, "R8", "status cleared", int'(stsEdge[0]), 0);
    irqIn[0] = 1'b0;
    waitNeg(5);
    check(stsEdge[0] == 1'b0, "R8", "falling edge with rising polarity", int'(stsEdge[0]), 0);
    writeReg(2'd2, 4'b0001);
    irqIn[0] = 1'b1;
    waitNeg(5);
    check(stsEdge[0] == 1'b0, "R8", "rising edge with falling polarity", int'(stsEdge[0]), 0);
    irqIn[0] = 1'b0;
    waitNeg(5);
    check(stsEdge[0] == 1'b1, "R8", "falling edge with falling polarity", int'(stsEdge[0]), 1);
  endtask

  task automatic testQuietRequest();
    int found = 0;
    writeReg(2'd0, 4'd4);
    writeReg(2'd1, 4'd0);
    irqIn = 2'b00;
    waitNeg(4);
    runFrame(4, 2);
    waitNeg(4);
    @(negedge clk); irqIn[0] = 1'b1;
    for (int i = 0; i < 10 && found == 0; i++) begin
      @(negedge clk);
      if (lineOe && !lineOut) found = 1;
    end
    check(found == 1, "R9", "request pulse seen in quiet mode", found, 1);
    hostLow = 1'b1;
    @(negedge clk);
    check(lineOe == 1'b0, "R9", "agent released after one clock", int'(lineOe), 0);
    waitNeg(4);
    hostLow = 1'b0;
    collectFrame(2);
    checkFrame(4, 1, 0, 0, "R9");
    irqIn[1] = 1'b1;
    expectSilent(20, "R9", "request from disabled input");
  endtask

  task automatic testContinuousNoRequest();
    runFrame(4, 3);
    check(quietMode == 1'b0, "R4", "back to continuous", int'(quietMode), 0);
    irqIn[0] = 1'b0;
    expectSilent(20, "R9", "request in continuous mode");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testResetSlotsZero();
    testNoSelfStart();
    testSingleSlot();
    testTwoSlots();
    testLevelLow();
    testDisabled();
    testBadStart();
    testStopWidth();
    testEdgeStatus();
    testQuietRequest();
    testContinuousNoRequest();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule